// File: doc/BRIEF.md
# Cache way determination table

This block is a small, fully associative table placed in front of a set-associative data cache. It remembers which cache way holds each recently touched cache line. Before every load or store, the core presents the byte address with a lookup strobe. The table answers in the same cycle with a hit flag and a way number. When the answer is a hit, the cache can enable only that one way for both its tag and data arrays. When the answer is a miss, the cache reads all ways as usual.

A lookup that misses claims an entry on the next clock edge. That entry is marked pending, because the way is not known yet. When the cache controller has resolved the way, it reports the line address and the way on the update port. The way is then written into the matching entry, and the pending mark is cleared. The table ignores cache evictions and invalidations. A stale entry therefore stays until it is overwritten: an access through a stale way simply misses in the cache tags, and the cache refills the line.

Free entries are used first. Once every entry is occupied, a wrapping pointer picks the victim in first-in, first-out order. The entry count and the width of the way field are parameters.

Top module: `way_locator`

## Requirements
- R1: After reset every entry is empty, so the first lookup reports `hit_o` = 0.
- R2: The line tag is address bits [31:5]. Addresses that differ only in bits [4:0] share an entry. Addresses that differ in bit 5 or above do not share an entry.
- R3: A lookup that misses allocates an entry at the next clock edge. Until that entry's way has been written, a lookup of the same line reports `hit_o` = 0.
- R4: An update whose `upd_addr` matches an allocated entry writes `upd_way` into that entry and clears its pending mark. From the next cycle, a lookup of that line returns `hit_o` = 1 in the same cycle, with `way_o` equal to the written way. Any value from 0 to 2^WAY_W-1 is accepted.
- R5: Looking up a line again while its entry is still pending reuses that entry, so no second entry is allocated for the same line.
- R6: While any entry is empty, an allocation takes an empty entry, and no occupied entry is displaced.
- R7: When the table is full, a missing lookup replaces the entry under the replacement pointer. After reset the pointer is 0. It advances by one on each replacing allocation, it wraps at the entry count, and lookups that hit do not move it.
- R8: Entries are never invalidated. An update to an entry that already holds a way overwrites that way. An update whose line is not in the table is ignored.
- R9: While `look_valid` is 0, `hit_o` is 0 and no entry is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| look_valid | input | 1 | Lookup strobe for the current access |
| look_addr | input | 32 | Byte address of the access |
| hit_o | output | 1 | The line's way is known |
| way_o | output | WAY_W | Way holding the line; valid when `hit_o` is 1 |
| upd_valid | input | 1 | Way report from the cache controller |
| upd_addr | input | 32 | Byte address of the reported line |
| upd_way | input | WAY_W | Way resolved by the cache controller |

## Verification
The bench builds the table with 8 entries and a 3-bit way field. With these values, filling the table takes only eight misses, and a further eight replacing misses walk the replacement pointer through a full wrap back to entry 0. Every way code from 0 to 7 is also written and read back. Because the table is this small, a duplicate allocation caused by a pending line shows up at the ports: it evicts a line that should still hit.

// File: rtl/wl_pkg.sv
// Shared types for the way determination table.
// Assumes: nothing beyond IEEE 1800-2017.
package wl_pkg;
    // How the current lookup obtains an entry.
    typedef enum logic [1:0] {
        AK_NONE  = 2'd0,
        AK_FREE  = 2'd1,
        AK_EVICT = 2'd2
    } alloc_kind_t;
endpackage

// File: rtl/wl_match.sv
// Fully associative tag comparator.
// Compares one line tag against every occupied entry and returns a match vector.
// Assumes: the store never holds two occupied entries with the same tag.
module wl_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 27
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [TAG_W-1:0]                key,
    input  logic [ENTRIES-1:0]              occ,
    input  logic [ENTRIES-1:0][TAG_W-1:0]   tags,
    output logic [ENTRIES-1:0]              hit_vec
);
    // One comparator per entry.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = occ[i] && (tags[i] == key);
    end

    // R2: a line tag never matches more than one entry.
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/wl_alloc.sv
// Victim selection.
// Picks the lowest-numbered empty entry. When none is empty, it picks the
// entry under a wrapping replacement pointer, then advances that pointer.
// Assumes: alloc_req is asserted only when a lookup missed.
module wl_alloc
    import wl_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    input  logic [ENTRIES-1:0] occ,
    output logic [IDX_W-1:0]   alloc_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;
    alloc_kind_t      kind;

    // Lowest empty entry; scanned from the top so that the lowest one wins.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Classify the allocation and choose its target.
    always_comb begin
        if (!alloc_req)    kind = AK_NONE;
        else if (any_free) kind = AK_FREE;
        else               kind = AK_EVICT;
        alloc_idx = (kind == AK_EVICT) ? ptr_q : free_idx;
    end

    // Replacement pointer: steps only on a replacing allocation, wraps at ENTRIES.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (kind == AK_EVICT)
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    // R7: with no allocation request, the pointer holds.
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |=> $stable(ptr_q));
endmodule

// File: rtl/wl_store.sv
// Entry storage: occupied flag, pending flag, line tag and way for each entry.
// An allocation writes a new tag and marks the entry pending. An update writes
// the way into its matching entries and clears pending. Nothing invalidates an entry.
// Assumes: upd_hit holds at most one bit set; allocation wins on the same entry.
module wl_store #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 27,
    parameter int WAY_W   = 3,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_en,
    input  logic [IDX_W-1:0]                alloc_idx,
    input  logic [TAG_W-1:0]                alloc_tag,
    input  logic [ENTRIES-1:0]              upd_hit,
    input  logic [WAY_W-1:0]                upd_way,
    output logic [ENTRIES-1:0]              occ_q,
    output logic [ENTRIES-1:0]              pend_q,
    output logic [ENTRIES-1:0][TAG_W-1:0]   tag_q,
    output logic [ENTRIES-1:0][WAY_W-1:0]   way_q
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic take;
        assign take = alloc_en && (alloc_idx == IDX_W'(i));

        // Per-entry state update: allocation first, then way fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_q[i]  <= 1'b0;
                pend_q[i] <= 1'b0;
                tag_q[i]  <= '0;
                way_q[i]  <= '0;
            end else if (take) begin
                occ_q[i]  <= 1'b1;
                pend_q[i] <= 1'b1;
                tag_q[i]  <= alloc_tag;
            end else if (upd_hit[i]) begin
                pend_q[i] <= 1'b0;
                way_q[i]  <= upd_way;
            end
        end
    end

    // R3: a freshly allocated entry is occupied and pending.
    a_r3_alloc_pending: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> (occ_q[$past(alloc_idx)] && pend_q[$past(alloc_idx)]));
endmodule

// File: rtl/way_locator.sv
// Way determination table (top).
// The lookup is combinational from look_addr to hit_o/way_o. A missing lookup
// allocates a pending entry at the clock edge. The update port fills the way
// of an entry whose line matches upd_addr.
// Assumes: only one lookup per cycle; an update and a lookup may share a cycle.
module way_locator #(
    parameter int ENTRIES  = 8,
    parameter int WAY_W    = 3,
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 5,
    localparam int TAG_W   = ADDR_W - LINE_OFF,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              look_valid,
    input  logic [31:0]       look_addr,
    output logic              hit_o,
    output logic [WAY_W-1:0]  way_o,
    input  logic              upd_valid,
    input  logic [31:0]       upd_addr,
    input  logic [WAY_W-1:0]  upd_way
);
    logic [TAG_W-1:0]              look_tag, upd_tag;
    logic [ENTRIES-1:0]            occ, pend;
    logic [ENTRIES-1:0][TAG_W-1:0] tags;
    logic [ENTRIES-1:0][WAY_W-1:0] ways;
    logic [ENTRIES-1:0]            look_vec, upd_vec, upd_hit;
    logic [IDX_W-1:0]              alloc_idx;
    logic                          alloc_en;

    assign look_tag = look_addr[ADDR_W-1:LINE_OFF];
    assign upd_tag  = upd_addr[ADDR_W-1:LINE_OFF];

    wl_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_look_cmp (
        .clk(clk), .rst_n(rst_n), .key(look_tag), .occ(occ), .tags(tags),
        .hit_vec(look_vec));

    wl_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_upd_cmp (
        .clk(clk), .rst_n(rst_n), .key(upd_tag), .occ(occ), .tags(tags),
        .hit_vec(upd_vec));

    // A pending line still counts as present, so it is not allocated twice.
    assign alloc_en = look_valid && (look_vec == '0);
    assign upd_hit  = upd_valid ? upd_vec : '0;

    wl_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_en), .occ(occ),
        .alloc_idx(alloc_idx));

    wl_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_store (
        .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
        .alloc_tag(look_tag), .upd_hit(upd_hit), .upd_way(upd_way),
        .occ_q(occ), .pend_q(pend), .tag_q(tags), .way_q(ways));

    // Hit flag and way: OR of the way fields of the filled entries that match.
    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_valid && look_vec[i] && !pend[i]) begin
                hit_o = 1'b1;
                way_o = way_o | ways[i];
            end
        end
    end

    // R9: a hit is never reported without a lookup strobe.
    a_r9_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> look_valid);
endmodule

// File: tb/way_locator_tb.sv
// Directed bench for way_locator: one task per scenario, each checking its own results.
module way_locator_tb;
    localparam int ENTRIES = 8;
    localparam int WAY_W   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             look_valid = 1'b0;
    logic [31:0]      look_addr = '0;
    logic             hit_o;
    logic [WAY_W-1:0] way_o;
    logic             upd_valid = 1'b0;
    logic [31:0]      upd_addr = '0;
    logic [WAY_W-1:0] upd_way = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    way_locator #(.ENTRIES(ENTRIES), .WAY_W(WAY_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .look_valid(look_valid), .look_addr(look_addr),
        .hit_o(hit_o), .way_o(way_o), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_way(upd_way));

    // Line address n, with a byte offset inside the line.
    function automatic logic [31:0] line(input int n, input int off = 0);
        return 32'h4000_0000 + 32'(n) * 32'd32 + 32'(off);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; look_valid = 1'b0; upd_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Lookup: drive at the falling edge, check before the rising edge.
    task automatic look(input logic [31:0] a, input bit exp_hit,
                        input int exp_way, input string req);
        @(negedge clk);
        look_valid = 1'b1; look_addr = a;
        #1;
        checks++;
        if (hit_o !== exp_hit || (exp_hit && way_o !== WAY_W'(exp_way))) begin
            errors++;
            $display("FAIL %s addr=%h: hit=%0b way=%0d expected hit=%0b way=%0d",
                     req, a, hit_o, way_o, exp_hit, exp_way);
        end
        @(posedge clk); #1;
        look_valid = 1'b0;
    endtask

    task automatic upd(input logic [31:0] a, input int w);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = a; upd_way = WAY_W'(w);
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    // R1: an empty table misses.
    task automatic t_reset();
        do_reset();
        look(line(3), 1'b0, 0, "R1 empty after reset");
    endtask

    // R3, R4, R2: pending entry misses, fill makes it hit, tag is bits [31:5].
    task automatic t_pending();
        do_reset();
        look(line(1), 1'b0, 0, "R3 first lookup misses");
        look(line(1), 1'b0, 0, "R3 pending entry gives no hit");
        upd(line(1), 6);
        look(line(1), 1'b1, 6, "R4 filled way returned");
        look(line(1, 31), 1'b1, 6, "R2 offset bits ignored");
        look(line(2), 1'b0, 0, "R2 bit 5 differs");
    endtask

    // R9: no hit and no allocation while the strobe is low.
    task automatic t_strobe();
        do_reset();
        @(negedge clk);
        look_valid = 1'b0; look_addr = line(9);
        @(posedge clk); #1;
        upd(line(9), 3);
        look(line(9), 1'b0, 0, "R9 strobe low allocated nothing");
        upd(line(9), 3);
        @(negedge clk);
        look_valid = 1'b0; look_addr = line(9);
        #1;
        checks++;
        if (hit_o !== 1'b0) begin
            errors++;
            $display("FAIL R9 strobe low: hit=%0b expected 0", hit_o);
        end
        look(line(9), 1'b1, 3, "R9 strobe high hits");
    endtask

    // R5: repeated lookups of a pending line take one entry only.
    task automatic t_nodup();
        do_reset();
        for (int k = 0; k < 4; k++) look(line(20), 1'b0, 0, "R5 pending repeat");
        for (int i = 1; i < ENTRIES; i++) look(line(20 + i), 1'b0, 0, "R5 fill table");
        for (int i = 0; i < ENTRIES; i++) upd(line(20 + i), i);
        for (int i = 0; i < ENTRIES; i++) look(line(20 + i), 1'b1, i, "R5 no duplicate");
    endtask

    // R6, R7: free entries first, then FIFO replacement with wrap.
    task automatic t_fifo();
        do_reset();
        for (int i = 0; i < ENTRIES; i++) look(line(40 + i), 1'b0, 0, "R6 allocate");
        for (int i = 0; i < ENTRIES; i++) upd(line(40 + i), 7 - i);
        for (int i = 0; i < ENTRIES; i++) look(line(40 + i), 1'b1, 7 - i, "R6 all kept");
        look(line(60), 1'b0, 0, "R7 miss when full");           // replaces entry 0 (line 40)
        upd(line(60), 5);
        look(line(47), 1'b1, 0, "R7 newest line kept");
        look(line(40), 1'b0, 0, "R7 oldest replaced");           // replaces entry 1 (line 41)
        look(line(42), 1'b1, 5, "R7 hit does not move pointer");
        look(line(41), 1'b0, 0, "R7 second victim");             // replaces entry 2 (line 42)
        look(line(43), 1'b1, 4, "R7 entry 3 still held");
        for (int i = 0; i < 5; i++) look(line(70 + i), 1'b0, 0, "R7 walk to top");
        look(line(60), 1'b1, 5, "R7 entry 0 kept before wrap");
        look(line(80), 1'b0, 0, "R7 wrap miss");                 // replaces entry 0 (line 60)
        look(line(60), 1'b0, 0, "R7 pointer wrapped to 0");
    endtask

    // R8: overwrite of a filled way; update for an absent line is ignored.
    task automatic t_update();
        do_reset();
        look(line(90), 1'b0, 0, "R8 allocate");
        upd(line(90), 2);
        look(line(90), 1'b1, 2, "R8 first way");
        upd(line(90), 5);
        look(line(90), 1'b1, 5, "R8 way overwritten");
        upd(line(91), 1);
        look(line(91), 1'b0, 0, "R8 absent update ignored");
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pending();
        t_strobe();
        t_nodup();
        t_fifo();
        t_update();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule